// File: doc/BRIEF.md
# Printer-Port Byte Strobe Transmitter

This block drains bytes from a small internal queue onto an eight-bit parallel data bus toward a printer-style peripheral, using the classic strobe/busy handshake. For every byte it drives the data bus, waits out a setup interval, pulses an active-low strobe for a fixed width, and then waits for the peripheral to raise and later drop its busy line before it moves on. Every interval is set in nanoseconds and turned into a whole number of clock cycles, rounded up, from a clock-period parameter. With the defaults (10 ns clock), setup is 60 cycles, strobe width 60, hold after strobe 45, busy-release-to-next-strobe 68, busy-release-to-data-change 8, and the busy wait limit 200.

Bytes enter through a valid/ready port. A byte is taken on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the queue is full, and the producer must then hold `in_valid` and `in_data` steady until it rises again. A byte stays in the queue until the peripheral has completed its busy cycle for it. If busy never shows up, a sticky error flag is raised and the same byte is sent again. The busy input is asynchronous and goes through a two-flop synchronizer before the control logic uses it.

Top module: `strobe_byte_tx`

## Requirements
- R1: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low while FIFO_DEPTH bytes are queued. Bytes appear on `pd` in acceptance order, with `in_data` bit k driven on `pd` bit k.
- R2: `pd` holds the byte for at least 60 cycles before `strobe_n` falls. When nothing else delays the strobe, the interval is exactly 60 cycles.
- R3: `strobe_n` stays low for exactly 60 cycles per byte.
- R4: After a strobe, `pd` keeps its value until the peripheral has raised and then dropped busy. It also keeps it for at least 45 cycles after `strobe_n` rises and at least 8 cycles after busy falls.
- R5: At least 68 cycles separate a fall of busy from the next fall of `strobe_n`.
- R6: With the queue empty, `pd` keeps the last byte sent and `strobe_n` stays high.
- R7: If busy is not seen within 200 cycles after `strobe_n` rises, `timeout_err` goes high and stays high until reset. The byte is not dropped: it is strobed again, and the bytes behind it then follow in order.
- R8: In reset, `strobe_n` = 1, `pd` = 0x00, `in_ready` = 1 and `timeout_err` = 0.
- R9: `idle` is high exactly when the queue is empty and no byte is in flight. `strobe_n` is high whenever `idle` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Queue can take a byte |
| in_data | input | 8 | Offered byte |
| pd | output | 8 | Parallel data bus to the peripheral |
| strobe_n | output | 1 | Active-low data strobe |
| busy | input | 1 | Peripheral busy, asynchronous |
| idle | output | 1 | Queue empty and handshake at rest |
| timeout_err | output | 1 | Sticky: busy never answered a strobe |

## Verification
The hardest case to reach from the ports is the retry after a busy timeout. It needs a peripheral that stays silent while the queue is full, then starts answering part-way through a retry. The bench gets there by switching its peripheral model off, filling the queue, waiting for `timeout_err`, and switching the model back on. It then checks that the first byte comes out again, followed by the rest in order. The two hold limits are each made the binding one by back-to-back pairs: in one pair the peripheral drops busy one cycle after the strobe, so the 45-cycle hold governs; in the other it holds busy for 40 cycles, so the release-side limits govern.

// File: rtl/strobe_tx_pkg.sv
package strobe_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT_BUSY,
    ST_WAIT_FREE
  } tx_state_e;

  // Round a nanosecond interval up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/stx_sync2.sv
module stx_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/stx_since.sv
// Cycles elapsed since the last clear, saturating; reset leaves it saturated
// so that no interval gates the first byte.
module stx_since #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= SAT;
    else if (clr)        cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [NW-1:0] FULLN = NW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [NW-1:0] fill;
  logic          do_push, do_pop;

  assign empty   = (fill == '0);
  assign full    = (fill == FULLN);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/strobe_byte_tx.sv
module strobe_byte_tx
  import strobe_tx_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int T_SETUP_NS  = 600,
  parameter int T_STROBE_NS = 600,
  parameter int T_HOLD_NS   = 450,
  parameter int T_RECOV_NS  = 680,
  parameter int T_DCHG_NS   = 80,
  parameter int T_TMO_NS    = 2000,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic [7:0] pd,
  output logic       strobe_n,
  input  logic       busy,
  output logic       idle,
  output logic       timeout_err
);
  localparam int N_SETUP  = ns_to_cycles(T_SETUP_NS,  CLK_NS);
  localparam int N_STROBE = ns_to_cycles(T_STROBE_NS, CLK_NS);
  localparam int N_HOLD   = ns_to_cycles(T_HOLD_NS,   CLK_NS);
  localparam int N_RECOV  = ns_to_cycles(T_RECOV_NS,  CLK_NS);
  localparam int N_DCHG   = ns_to_cycles(T_DCHG_NS,   CLK_NS);
  localparam int N_TMO    = ns_to_cycles(T_TMO_NS,    CLK_NS);
  localparam int N_MAX    = max_of(max_of(max_of(N_SETUP, N_STROBE), max_of(N_HOLD, N_RECOV)),
                                   max_of(N_DCHG, N_TMO));
  localparam int CW       = $clog2(N_MAX + 1) + 1;

  // A counter value of N-1 sampled at an edge means N full cycles have elapsed.
  localparam logic [CW-1:0] L_SETUP  = CW'(N_SETUP  - 1);
  localparam logic [CW-1:0] L_STROBE = CW'(N_STROBE - 1);
  localparam logic [CW-1:0] L_HOLD   = CW'(N_HOLD   - 1);
  localparam logic [CW-1:0] L_RECOV  = CW'(N_RECOV  - 1);
  localparam logic [CW-1:0] L_DCHG   = CW'(N_DCHG   - 1);
  localparam logic [CW-1:0] L_TMO    = CW'(N_TMO    - 1);

  // Interval counters: 0 = time in state, 1 = since strobe release, 2 = since busy release
  localparam int NCNT = 3;

  tx_state_e     state, state_nx;
  logic          busy_s;
  logic [7:0]    head;
  logic          q_empty, q_full;
  logic          load, pop, tmo_hit;
  logic [NCNT-1:0] clr_v;
  logic [CW-1:0] cnt_v [NCNT];
  logic [CW-1:0] ph_cnt, off_cnt, rel_cnt;

  stx_sync2 u_busy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (busy),
    .q     (busy_s)
  );

  stx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && in_ready),
    .wdata (in_data),
    .pop   (pop),
    .head  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  assign in_ready = !q_full;

  assign clr_v[0] = (state_nx != state);
  assign clr_v[1] = (state == ST_STROBE) && (state_nx == ST_WAIT_BUSY);
  assign clr_v[2] = pop;

  for (genvar i = 0; i < NCNT; i++) begin : g_since
    stx_since #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_v[i]),
      .cnt   (cnt_v[i])
    );
  end

  assign ph_cnt  = cnt_v[0];
  assign off_cnt = cnt_v[1];
  assign rel_cnt = cnt_v[2];

  always_comb begin
    state_nx = state;
    load     = 1'b0;
    pop      = 1'b0;
    tmo_hit  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!q_empty && rel_cnt >= L_DCHG && off_cnt >= L_HOLD) begin
          load     = 1'b1;
          state_nx = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (ph_cnt >= L_SETUP && rel_cnt >= L_RECOV) state_nx = ST_STROBE;
      end
      ST_STROBE: begin
        if (ph_cnt >= L_STROBE) state_nx = ST_WAIT_BUSY;
      end
      ST_WAIT_BUSY: begin
        if (busy_s) begin
          state_nx = ST_WAIT_FREE;
        end else if (ph_cnt >= L_TMO) begin
          tmo_hit  = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      ST_WAIT_FREE: begin
        if (!busy_s) begin
          pop      = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pd          <= '0;
      strobe_n    <= 1'b1;
      timeout_err <= 1'b0;
    end else begin
      state    <= state_nx;
      strobe_n <= (state_nx != ST_STROBE);
      if (load)    pd          <= head;
      if (tmo_hit) timeout_err <= 1'b1;
    end
  end

  assign idle = (state == ST_IDLE) && q_empty;

endmodule

// File: rtl/stx_checker.sv
module stx_checker
  import strobe_tx_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int T_SETUP_NS  = 600,
  parameter int T_STROBE_NS = 600,
  parameter int T_HOLD_NS   = 450
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pd,
  input logic       strobe_n,
  input logic       idle,
  input logic       timeout_err
);
  localparam int N_SETUP  = ns_to_cycles(T_SETUP_NS,  CLK_NS);
  localparam int N_STROBE = ns_to_cycles(T_STROBE_NS, CLK_NS);
  localparam int N_HOLD   = ns_to_cycles(T_HOLD_NS,   CLK_NS);
  localparam int SAT      = 32'h3fff_ffff;

  logic [7:0] pd_q;
  int stab_cnt, low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q     <= '0;
      stab_cnt <= SAT;
      low_cnt  <= 0;
      high_cnt <= SAT;
    end else begin
      pd_q     <= pd;
      stab_cnt <= (pd != pd_q) ? 0 : ((stab_cnt < SAT) ? stab_cnt + 1 : SAT);
      low_cnt  <= strobe_n ? 0 : low_cnt + 1;
      high_cnt <= !strobe_n ? 0 : ((high_cnt < SAT) ? high_cnt + 1 : SAT);
    end
  end

  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> stab_cnt >= N_SETUP - 1);

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> low_cnt >= N_STROBE);

  a_r4_data_frozen_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> $stable(pd));

  a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pd != $past(pd)) |-> high_cnt >= N_HOLD);

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);

  a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> strobe_n);
endmodule

bind strobe_byte_tx stx_checker #(
  .CLK_NS      (CLK_NS),
  .T_SETUP_NS  (T_SETUP_NS),
  .T_STROBE_NS (T_STROBE_NS),
  .T_HOLD_NS   (T_HOLD_NS)
) u_stx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .pd          (pd),
  .strobe_n    (strobe_n),
  .idle        (idle),
  .timeout_err (timeout_err)
);

// File: tb/tb_strobe_byte_tx.sv
module tb_strobe_byte_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int E_SETUP    = (600 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_STROBE   = (600 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_HOLD     = (450 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_RECOV    = (680 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int E_DCHG     = (80  + CLK_PERIOD - 1) / CLK_PERIOD;

  // {byte, cycles strobe-fall to busy-rise, cycles strobe-rise to busy-fall}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'h5A, 8'd1,  8'd1},
    {8'hA5, 8'd10, 8'd5},
    {8'hFF, 8'd40, 8'd20},
    {8'h01, 8'd3,  8'd2},
    {8'h80, 8'd25, 8'd12},
    {8'h3C, 8'd2,  8'd30}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic [7:0] pd;
  logic strobe_n;
  logic busy = 1'b0;
  logic idle;
  logic timeout_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  bit per_en = 1;
  int per_dly = 1;
  int per_len = 1;

  int log_pd [64];
  int log_n = 0;
  int last_setup, last_width, last_hold, last_dchg, last_recov;
  int pd_age = 1000000, low_cnt = 0, since_rise = 1000000, since_bfall = 1000000;
  logic [7:0] prev_pd = '0;
  logic prev_stb = 1'b1, prev_busy = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strobe_byte_tx #(.CLK_NS(CLK_PERIOD), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pd(pd), .strobe_n(strobe_n), .busy(busy),
    .idle(idle), .timeout_err(timeout_err)
  );

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  // Peripheral model: raises busy after a delay, drops it after the strobe ends.
  initial begin
    forever begin
      @(negedge strobe_n);
      if (per_en) begin
        repeat (per_dly) @(posedge clk);
        #1 busy = 1'b1;
        while (!strobe_n) @(posedge clk);
        repeat (per_len) @(posedge clk);
        #1 busy = 1'b0;
      end
    end
  end

  // Port monitor, sampling mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pd != prev_pd) begin
        last_hold = since_rise + 1;
        last_dchg = since_bfall + 1;
      end
      if (prev_stb && !strobe_n) begin
        last_setup = pd_age;
        last_recov = since_bfall + 1;
        if (log_n < 64) log_pd[log_n] = int'(pd);
        log_n++;
      end
      if (!prev_stb && strobe_n) last_width = low_cnt;
      pd_age      = (pd != prev_pd) ? 1 : pd_age + 1;
      low_cnt     = !strobe_n ? low_cnt + 1 : 0;
      since_rise  = (!prev_stb && strobe_n) ? 0 : since_rise + 1;
      since_bfall = (prev_busy && !busy) ? 0 : since_bfall + 1;
    end
    prev_pd   = pd;
    prev_stb  = strobe_n;
    prev_busy = busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_strobes(input int n);
    for (int k = 0; k < 5000 && log_n < n; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (idle && !busy) break;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R8 reset values
    check(strobe_n == 1'b1, "R8 strobe_n in reset", int'(strobe_n), 1);
    check(pd == 8'h00, "R8 pd in reset", int'(pd), 0);
    check(in_ready == 1'b1, "R8 in_ready in reset", int'(in_ready), 1);
    check(timeout_err == 1'b0, "R8 timeout_err in reset", int'(timeout_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(idle == 1'b1, "R9 idle after reset", int'(idle), 1);

    // Table walk: one byte at a time, varied peripheral timing.
    for (int v = 0; v < NV; v++) begin
      logic [7:0] b;
      b       = VEC[v][23:16];
      per_dly = int'(VEC[v][15:8]);
      per_len = int'(VEC[v][7:0]);
      push(b);
      wait_strobes(v + 1);
      check(log_pd[v] == int'(b), "R1 byte on pd at strobe", log_pd[v], int'(b));
      check(last_setup == E_SETUP, "R2 setup interval", last_setup, E_SETUP);
      wait_idle();
      check(last_width == E_STROBE, "R3 strobe width", last_width, E_STROBE);
      repeat (20) @(negedge clk);
      check(pd == b && strobe_n, "R6 pd held while queue empty", int'(pd), int'(b));
      check(idle == 1'b1, "R9 idle after byte done", int'(idle), 1);
    end

    // Back-to-back, busy released almost at once: hold after strobe binds.
    per_dly = 3; per_len = 1;
    push(8'h11);
    push(8'h22);
    wait_strobes(NV + 2);
    check(log_pd[NV] == 32'h11 && log_pd[NV+1] == 32'h22, "R1 order of pair",
          log_pd[NV+1], 32'h22);
    check(last_hold >= E_HOLD, "R4 hold after strobe rise", last_hold, E_HOLD);
    check(last_recov >= E_RECOV, "R5 recovery after busy fall", last_recov, E_RECOV);
    wait_idle();

    // Back-to-back, long busy: release-side limits bind.
    per_dly = 5; per_len = 40;
    push(8'h33);
    push(8'h44);
    wait_strobes(NV + 4);
    check(log_pd[NV+3] == 32'h44, "R1 order of second pair", log_pd[NV+3], 32'h44);
    check(last_dchg >= E_DCHG, "R4 data change after busy fall", last_dchg, E_DCHG);
    check(last_hold > E_HOLD, "R4 data waits for busy release", last_hold, E_HOLD + 1);
    check(last_recov >= E_RECOV, "R5 recovery with long busy", last_recov, E_RECOV);
    wait_idle();

    // Silent peripheral: back-pressure, timeout and retry.
    per_en = 0;
    per_dly = 4; per_len = 3;
    for (int i = 0; i < DEPTH; i++) push(8'hE0 + 8'(i));
    @(negedge clk);
    check(in_ready == 1'b0, "R1 in_ready low when full", int'(in_ready), 0);
    for (int k = 0; k < 3000 && !timeout_err; k++) @(negedge clk);
    check(timeout_err == 1'b1, "R7 timeout flag raised", int'(timeout_err), 1);
    check(log_pd[log_n-1] == 32'hE0, "R7 first byte strobed", log_pd[log_n-1], 32'hE0);
    per_en = 1;
    for (int k = 0; k < 20000 && !(idle && !busy); k++) @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      check(log_pd[log_n-DEPTH+i] == 32'hE0 + i, "R7 byte kept and resent in order",
            log_pd[log_n-DEPTH+i], 32'hE0 + i);
    check(timeout_err == 1'b1, "R7 flag stays set", int'(timeout_err), 1);
    repeat (300) @(negedge clk);
    check(pd == 8'hE3 && strobe_n, "R6 last byte held", int'(pd), 32'hE3);
    check(in_ready == 1'b1 && idle, "R9 idle after drain", int'(idle), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule